// File: doc/BRIEF.md
# Potentiometer Wiper Register Controller

This block holds the live tap position of a digitally controlled potentiometer in a 7-bit register. It also decodes a byte-wide access bus, of the kind an upstream serial-bus slave produces, into a nonvolatile byte array. The topmost byte of that array is the stored start-up position of the wiper. The byte below it holds a volatile steering flag. The two bytes below that are reserved. Everything else is general-purpose storage that passes straight through to the array.

When the flag is clear, the topmost address behaves as persistent storage: reads return the stored byte, and writes update both the stored byte and the live wiper. When the flag is set, the same address reaches only the live wiper. Sequential accesses take the address that follows the previous access, wrapping inside the page. This lets one burst set the flag and then write the wiper.

After reset the wiper sits at mid-scale during a settling window. It is then loaded from the stored byte. Only after that load does the block report itself ready and accept accesses.

Top module: `wiper_reg_ctrl`

## Requirements
- R1: While reset is high, and for BOOT_WAIT+1 clock edges after reset falls, `wiper` reads 0x40 (mid-scale), `ready` is 0 and `bus_wait` is 1.
- R2: On the BOOT_WAIT+2nd edge after reset falls, `wiper` takes bits 6..0 of the stored top byte (address all ones), `ready` becomes 1 and `bus_wait` becomes 0. `ready` then stays high until the next reset.
- R3: A write to a general-purpose address (every address below top-3) stores the byte, and a later read of that address returns it.
- R4: Writes to the reserved addresses top-3 and top-2 change neither the flag nor the wiper, and reads of those addresses return 0x00.
- R5: Address top-1 holds the volatile flag in data bit 7. The flag is 0 after reset. A read of top-1 returns the flag in bit 7 with bits 6..0 equal to zero.
- R6: A write to top-1 whose data bits 6..0 are not all zero leaves the flag unchanged.
- R7: A read of the top address returns the live wiper when the flag is 1, and the stored byte when the flag is 0. Bit 7 of the result is always 0.
- R8: A write to the top address sets the wiper to data bits 6..0, with bit 7 dropped. The stored byte is updated to the same value only when the flag is 0.
- R9: An access with `bus_seq`=1 ignores `bus_addr` and uses the previous access address plus one. Only the low PAGE_W bits increment, and they wrap, so the access stays inside the page.
- R10: Writes presented while `ready` is 0 have no effect on storage.
- R11: A read accepted on clock edge E drives `bus_rdata` with `bus_rvalid`=1 after edge E+1. `bus_rvalid` is 0 after any edge whose predecessor accepted no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_seq | input | 1 | Use previous address plus one, within the page |
| bus_wr | input | 1 | Write strobe (wins over read) |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_wait | output | 1 | Accesses are held off while high |
| bus_rdata | output | DATA_W | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| ready | output | 1 | Power-up load complete |
| wiper | output | WIPER_W | Live wiper tap code |

## Verification
The bench builds the block with ADDR_W=6, PAGE_W=2 and BOOT_WAIT=3. This shrinks the array to 64 bytes, so every general-purpose byte can be written and read back, partly through page-wrapping sequential accesses, in a single sweep. With the short settling window, the boot sequence can be checked edge by edge twice: once from an empty array and once after a stored wiper value has been written. All 128 wiper codes are swept through the top address with bit 7 toggled. Both flag states and the rejected flag writes are exercised against an arithmetic reference model of the address map.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [1:0] {
    REG_GP    = 2'd0,
    REG_RSV   = 2'd1,
    REG_CTRL  = 2'd2,
    REG_WIPER = 2'd3
  } region_t;

  typedef enum logic [1:0] {
    BOOT_SETTLE = 2'd0,
    BOOT_FETCH  = 2'd1,
    BOOT_LOAD   = 2'd2,
    BOOT_DONE   = 2'd3
  } boot_state_t;

  typedef struct packed {
    logic    valid;
    region_t region;
    logic    flag;
  } rd_stage_t;

endpackage

// File: rtl/wpc_region_dec.sv
module wpc_region_dec
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output region_t           region
);
  localparam logic [ADDR_W-1:0] A_TOP  = '1;
  localparam logic [ADDR_W-1:0] A_CTRL = A_TOP - 1'b1;
  localparam logic [ADDR_W-1:0] A_RSV1 = A_TOP - 2'd2;
  localparam logic [ADDR_W-1:0] A_RSV0 = A_TOP - 2'd3;

  always_comb begin
    if (addr == A_TOP)                         region = REG_WIPER;
    else if (addr == A_CTRL)                   region = REG_CTRL;
    else if (addr == A_RSV1 || addr == A_RSV0) region = REG_RSV;
    else                                       region = REG_GP;
  end
endmodule

// File: rtl/wpc_nv_array.sv
module wpc_nv_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // Erased state of the model: all bytes zero at start of time.
  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '0;
  end

  // Single port, read-first, so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    q <= cells[addr];
  end
endmodule

// File: rtl/wpc_boot_seq.sv
module wpc_boot_seq
  import wpc_pkg::*;
#(
  parameter int BOOT_WAIT = 4
) (
  input  logic clk,
  input  logic rst,
  output logic fetch,
  output logic load_stb,
  output logic ready
);
  localparam int CNT_W = (BOOT_WAIT > 1) ? $clog2(BOOT_WAIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BOOT_WAIT - 1);

  boot_state_t      state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BOOT_SETTLE;
      cnt_q   <= '0;
      ready   <= 1'b0;
    end else begin
      case (state_q)
        BOOT_SETTLE: begin
          if (cnt_q == CNT_LAST) state_q <= BOOT_FETCH;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
        BOOT_FETCH: state_q <= BOOT_LOAD;
        BOOT_LOAD: begin
          state_q <= BOOT_DONE;
          ready   <= 1'b1;
        end
        default: state_q <= BOOT_DONE;
      endcase
    end
  end

  assign fetch    = (state_q == BOOT_FETCH);
  assign load_stb = (state_q == BOOT_LOAD);

  p_ready_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  p_load_then_ready_r2: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> ready);
  p_fetch_before_load_r2: assert property (@(posedge clk) disable iff (rst)
    fetch |=> load_stb);
endmodule

// File: rtl/wiper_reg_ctrl.sv
module wiper_reg_ctrl
  import wpc_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 4,
  parameter int DATA_W    = 8,
  parameter int WIPER_W   = 7,
  parameter int BOOT_WAIT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_seq,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic               bus_wait,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  output logic               ready,
  output logic [WIPER_W-1:0] wiper
);
  localparam logic [ADDR_W-1:0]  TOP_ADDR   = '1;
  localparam logic [WIPER_W-1:0] RESET_CODE = {1'b1, {(WIPER_W-1){1'b0}}};
  localparam logic [PAGE_W-1:0]  PAGE_ONE   = PAGE_W'(1);
  localparam int                 PAD_W      = DATA_W - WIPER_W;

  // Power-up sequencing
  logic boot_fetch, load_stb;

  wpc_boot_seq #(.BOOT_WAIT(BOOT_WAIT)) u_boot (
    .clk      (clk),
    .rst      (rst),
    .fetch    (boot_fetch),
    .load_stb (load_stb),
    .ready    (ready)
  );

  assign bus_wait = ~ready;

  // Address formation: explicit or next-in-page
  logic [ADDR_W-1:0] ptr_q, eff_addr;
  logic [PAGE_W-1:0] page_off;
  logic              acc_wr, acc_rd;

  assign page_off = ptr_q[PAGE_W-1:0] + PAGE_ONE;
  assign eff_addr = bus_seq ? {ptr_q[ADDR_W-1:PAGE_W], page_off} : bus_addr;
  assign acc_wr   = ready & bus_wr;
  assign acc_rd   = ready & bus_rd & ~bus_wr;

  always_ff @(posedge clk) begin
    if (rst)                   ptr_q <= '0;
    else if (acc_wr || acc_rd) ptr_q <= eff_addr;
  end

  region_t region;

  wpc_region_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (eff_addr),
    .region (region)
  );

  // Volatile steering flag
  logic vol_q;

  always_ff @(posedge clk) begin
    if (rst)
      vol_q <= 1'b0;
    else if (acc_wr && region == REG_CTRL && bus_wdata[DATA_W-2:0] == '0)
      vol_q <= bus_wdata[DATA_W-1];
  end

  // Nonvolatile array
  logic              nv_we;
  logic [ADDR_W-1:0] nv_addr;
  logic [DATA_W-1:0] nv_wd, nv_q;

  assign nv_addr = boot_fetch ? TOP_ADDR : eff_addr;
  assign nv_we   = acc_wr & ((region == REG_GP) | ((region == REG_WIPER) & ~vol_q));
  assign nv_wd   = (region == REG_WIPER) ?
                   {{PAD_W{1'b0}}, bus_wdata[WIPER_W-1:0]} : bus_wdata;

  wpc_nv_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_nv (
    .clk   (clk),
    .we    (nv_we),
    .addr  (nv_addr),
    .wdata (nv_wd),
    .q     (nv_q)
  );

  // Live wiper: mid-scale, then stored value, then bus writes
  logic [WIPER_W-1:0] wiper_q;

  always_ff @(posedge clk) begin
    if (rst)                                  wiper_q <= RESET_CODE;
    else if (load_stb)                        wiper_q <= nv_q[WIPER_W-1:0];
    else if (acc_wr && region == REG_WIPER)   wiper_q <= bus_wdata[WIPER_W-1:0];
  end

  assign wiper = wiper_q;

  // Two-stage read return
  rd_stage_t          s1_q;
  logic [WIPER_W-1:0] s1_wiper_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q       <= '0;
      s1_wiper_q <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      s1_q.valid  <= acc_rd;
      s1_q.region <= region;
      s1_q.flag   <= vol_q;
      s1_wiper_q  <= wiper_q;
      bus_rvalid  <= s1_q.valid;
      if (s1_q.valid) begin
        case (s1_q.region)
          REG_GP:    bus_rdata <= nv_q;
          REG_RSV:   bus_rdata <= '0;
          REG_CTRL:  bus_rdata <= {s1_q.flag, {(DATA_W-1){1'b0}}};
          default:   bus_rdata <= s1_q.flag ? {{PAD_W{1'b0}}, s1_wiper_q}
                                            : {{PAD_W{1'b0}}, nv_q[WIPER_W-1:0]};
        endcase
      end
    end
  end

  p_wiper_held_boot_r1: assert property (@(posedge clk) disable iff (rst)
    (!ready && !load_stb) |=> $stable(wiper_q));
  p_busy_no_flag_r10: assert property (@(posedge clk) disable iff (rst)
    !ready |=> $stable(vol_q));
  p_reserved_inert_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && region == REG_RSV) |=> ($stable(vol_q) && $stable(wiper_q)));
  p_ctrl_reject_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && region == REG_CTRL && bus_wdata[DATA_W-2:0] != '0) |=> $stable(vol_q));
  p_wiper_write_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && region == REG_WIPER) |=> wiper_q == $past(bus_wdata[WIPER_W-1:0]));
  p_read_latency_r11: assert property (@(posedge clk) disable iff (rst)
    acc_rd |-> ##2 bus_rvalid);
  p_rvalid_cause_r11: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(acc_rd, 2));
  p_top_bit7_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(s1_q.region) == REG_WIPER) |-> !bus_rdata[DATA_W-1]);
endmodule

// File: tb/wiper_reg_ctrl_test.sv
module wiper_reg_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 6;
  localparam int PW  = 2;
  localparam int DW  = 8;
  localparam int WW  = 7;
  localparam int BW  = 3;
  localparam int TOP = (1 << AW) - 1;
  localparam int PMASK = (1 << PW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          seq = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wd = '0;
  logic          bwait, rvalid, rdy;
  logic [DW-1:0] rdata;
  logic [WW-1:0] wip;

  int ref_mem [TOP+1];
  int ref_flag, ref_wiper, ref_ptr;
  int n_checks = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_reg_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .WIPER_W(WW), .BOOT_WAIT(BW)) uut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_seq(seq), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wd), .bus_wait(bwait), .bus_rdata(rdata), .bus_rvalid(rvalid),
    .ready(rdy), .wiper(wip)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input int a, input bit s);
    return s ? ((ref_ptr & ~PMASK) | ((ref_ptr + 1) & PMASK)) : a;
  endfunction

  function automatic int exp_rd(input int e);
    if (e <= TOP - 4) return ref_mem[e];
    if (e == TOP - 1) return ref_flag << 7;
    if (e == TOP)     return ref_flag ? ref_wiper : (ref_mem[TOP] & 127);
    return 0;
  endfunction

  task automatic wr_acc(input int a, input bit s, input int d);
    int e;
    @(negedge clk);
    addr = AW'(a); seq = s; wr = 1'b1; wd = DW'(d);
    e = eff(a, s);
    @(posedge clk);
    if (e <= TOP - 4) ref_mem[e] = d;
    else if (e == TOP - 1) begin
      if ((d & 127) == 0) ref_flag = (d >> 7) & 1;
    end else if (e == TOP) begin
      ref_wiper = d & 127;
      if (ref_flag == 0) ref_mem[TOP] = d & 127;
    end
    ref_ptr = e;
    @(negedge clk);
    wr = 1'b0; seq = 1'b0;
  endtask

  task automatic rd_acc(input int a, input bit s, input string req);
    int e, x;
    @(negedge clk);
    addr = AW'(a); seq = s; rd = 1'b1;
    e = eff(a, s);
    x = exp_rd(e);
    ref_ptr = e;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0; seq = 1'b0;
    @(posedge clk);
    #1;
    check({req, " rvalid"}, int'(rvalid), 1);
    check({req, " rdata"}, int'(rdata), x);
  endtask

  task automatic do_reset(input bit stray);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 wiper in reset", int'(wip), 'h40);
    check("R1 ready in reset", int'(rdy), 0);
    @(negedge clk);
    rst = 1'b0;
    ref_ptr = 0; ref_flag = 0; ref_wiper = 'h40;
    if (stray) begin
      addr = AW'(5); wr = 1'b1; wd = 8'hAA;   // R10: write while held off
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0;
      repeat (BW - 1) @(posedge clk);
    end else begin
      repeat (BW) @(posedge clk);
    end
    #1;
    check("R1 wiper settle", int'(wip), 'h40);
    check("R1 ready settle", int'(rdy), 0);
    check("R1 wait settle", int'(bwait), 1);
    @(posedge clk); #1;
    check("R1 wiper fetch", int'(wip), 'h40);
    check("R1 ready fetch", int'(rdy), 0);
    @(posedge clk); #1;
    check("R2 wiper loaded", int'(wip), ref_mem[TOP] & 127);
    check("R2 ready", int'(rdy), 1);
    check("R2 wait", int'(bwait), 0);
    ref_wiper = ref_mem[TOP] & 127;
    repeat (3) @(posedge clk); #1;
    check("R2 ready stays", int'(rdy), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i <= TOP; i++) ref_mem[i] = 0;
    do_reset(1'b1);

    rd_acc(5, 1'b0, "R10 held-off write");
    @(posedge clk); #1;
    check("R11 rvalid idle", int'(rvalid), 0);
    rd_acc(TOP - 1, 1'b0, "R5 flag after reset");

    // R3/R9 general-purpose sweep, explicit at page start, sequential inside
    for (int a = 0; a <= TOP - 4; a++) wr_acc(a, (a & PMASK) != 0, (a * 37 + 11) & 255);
    for (int a = 0; a <= TOP - 4; a++)
      rd_acc(a, (a & PMASK) != 0, ((a & PMASK) != 0) ? "R9 seq read" : "R3 read");

    // R4 reserved
    wr_acc(TOP - 3, 1'b0, 'hFF);
    wr_acc(TOP - 2, 1'b0, 'h80);
    check("R4 wiper kept", int'(wip), ref_wiper);
    rd_acc(TOP - 3, 1'b0, "R4 reserved lo");
    rd_acc(TOP - 2, 1'b0, "R4 reserved hi");
    rd_acc(TOP - 1, 1'b0, "R4 flag kept");

    // R7/R8 all wiper codes, flag clear, bit 7 toggled
    for (int c = 0; c < 128; c++) begin
      wr_acc(TOP, 1'b0, c | ((c & 1) << 7));
      check("R8 wiper code", int'(wip), c);
      rd_acc(TOP, 1'b0, "R7 stored read");
    end

    // Flag set: volatile only
    wr_acc(TOP - 1, 1'b0, 'h80);
    rd_acc(TOP - 1, 1'b0, "R5 flag set");
    wr_acc(TOP, 1'b0, 'h95);
    check("R8 volatile wiper", int'(wip), 'h15);
    rd_acc(TOP, 1'b0, "R7 live read");
    wr_acc(TOP - 1, 1'b0, 'h00);
    rd_acc(TOP, 1'b0, "R8 store untouched");
    check("R8 wiper kept", int'(wip), 'h15);

    // R6 rejected flag writes
    wr_acc(TOP - 1, 1'b0, 'h81);
    rd_acc(TOP - 1, 1'b0, "R6 reject set");
    wr_acc(TOP - 1, 1'b0, 'h80);
    wr_acc(TOP - 1, 1'b0, 'hC0);
    rd_acc(TOP - 1, 1'b0, "R6 reject clear");

    // R9 burst: flag byte then wiper byte, then wrap in page
    wr_acc(TOP - 1, 1'b0, 'h00);
    wr_acc(0, 1'b1, 'h2A);
    check("R9 burst wiper", int'(wip), 'h2A);
    rd_acc(TOP, 1'b0, "R9 burst stored");
    rd_acc(0, 1'b1, "R9 page wrap");

    // Second power-up from the stored value
    do_reset(1'b0);
    rd_acc(TOP - 1, 1'b0, "R5 flag cleared");
    rd_acc(7, 1'b0, "R3 retained");
    rd_acc(TOP, 1'b0, "R7 stored after boot");

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule